// File: doc/BRIEF.md
# SPI Interrupt Status and Test Unit

This block collects interrupt events from up to four SPI channels into one status register and drives a single level-sensitive interrupt line. Each channel presents its live transmit-space and receive-data flags together with its transfer direction and a turbo flag. The block decides from these whether the channel is raising a transmit-empty event or a receive-full event, and records each event in the status register. Software clears bits by writing ones to them. An enable register selects which recorded bits reach the interrupt line.

A built-in test facility lets software force every implemented status bit high. While the test facility is armed, clearing writes are refused. A soft-reset command returns every register to its default. The SPI shift logic and any DMA handling are outside this block.

Access uses a plain 32-bit register port. A write takes effect at the clock edge where `reg_wr` is high. A read strobe `reg_rd` returns its data one cycle later, qualified by `reg_rvalid`. There is no back-pressure: the requester must accept every read result in the cycle it is presented.

Top module: `spi_irq_unit`

## Requirements
- R1: After reset, reads return 0x91 at 0x00 (identity) and 1 at 0x04 (reset-done). They return 4 at 0x1C (mode control) and 0 at 0x08 (config), 0x0C (status), 0x10 (enable), 0x14 (wake), 0x18 (test) and at any unmapped offset. Read data appears one cycle after the read strobe.
- R2: Channel n sets status bit 4n in any cycle where its transmit-space flag is high and its direction code is not receive-only. Direction codes are 0 = duplex, 1 = receive-only and 2 = transmit-only.
- R3: Channel n sets status bit 4n+2 in any cycle where all three hold: its receive-data flag is high, its direction code is not transmit-only, and its turbo flag is low.
- R4: A write to the status register clears exactly the bits written as one. Bits written as zero keep their value.
- R5: If an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The enable register keeps only the bits of mask 0x1777f. `irq` is high whenever status AND enable is non-zero.
- R7: While mode-control bit 3 and test bit 11 are both set, writes to the status register have no effect.
- R8: All status bits of mask 0x1777f are forced to one in two cases. The first is a test-register write with bit 11 set while mode-control bit 3 is set. The second is a mode-control write with bit 3 set while test bit 11 is already set.
- R9: Register widths are as follows. The test register keeps bits 11:0. Mode control keeps bits 3:0. Wake keeps bit 0. Config keeps the bits of mask 0x31d.
- R10: Writing the config register with bit 1 set performs a soft reset. Status, enable, wake and test are cleared, mode control reloads to 4, and config takes the written value under its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read result present (one cycle after reg_rd) |
| ch_txs | input | NUM_CH | Per-channel transmit-space flag |
| ch_rxs | input | NUM_CH | Per-channel receive-data flag |
| ch_mode | input | 2*NUM_CH | Per-channel direction code, channel n in bits 2n+1:2n |
| ch_turbo | input | NUM_CH | Per-channel turbo flag |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with NUM_CH = 4 and ADDR_W = 8, the largest channel count. This puts channel 3's events at bits 12 and 14 within reach, and makes the forced pattern exactly the full 0x1777f mask. Direction codes and turbo are mixed across channels within a single stimulus pulse, so that gated and ungated events are compared in one status read. The lockout and the force function are each entered through both orders of arming the two test bits.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_IDENT   = 8'h00;
  localparam logic [7:0] OFF_DONE    = 8'h04;
  localparam logic [7:0] OFF_CONFIG  = 8'h08;
  localparam logic [7:0] OFF_STATUS  = 8'h0C;
  localparam logic [7:0] OFF_ENABLE  = 8'h10;
  localparam logic [7:0] OFF_WAKE    = 8'h14;
  localparam logic [7:0] OFF_TEST    = 8'h18;
  localparam logic [7:0] OFF_MODECTL = 8'h1C;

  localparam logic [DATA_W-1:0] IDENT_VALUE = 32'h0000_0091;
  localparam logic [DATA_W-1:0] CONFIG_KEEP = 32'h0000_031D;

  localparam int SOFTRST_BIT = 1;
  localparam int TESTMODE_BIT = 3;
  localparam int FORCE_BIT = 11;
  localparam int TEST_W = 12;
  localparam int MODECTL_W = 4;
  localparam logic [MODECTL_W-1:0] MODECTL_DEFAULT = 4'h4;

  typedef enum logic [1:0] {
    XFER_DUPLEX  = 2'd0,
    XFER_RX_ONLY = 2'd1,
    XFER_TX_ONLY = 2'd2
  } xfer_mode_e;

  typedef struct packed {
    logic config_r;
    logic status_r;
    logic enable_r;
    logic wake_r;
    logic test_r;
    logic modectl_r;
  } wr_sel_t;

  // Bits that exist in status/enable: three per channel, spaced by four,
  // plus the shared overflow and wake bits.
  function automatic logic [DATA_W-1:0] impl_mask(input int nch);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < nch; n++) begin
      m[4*n]   = 1'b1;
      m[4*n+1] = 1'b1;
      m[4*n+2] = 1'b1;
    end
    m[3]  = 1'b1;
    m[16] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/spi_irq_event_gen.sv
module spi_irq_event_gen
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]   txs,
  input  logic [NUM_CH-1:0]   rxs,
  input  logic [NUM_CH-1:0]   turbo,
  input  logic [2*NUM_CH-1:0] mode,
  output logic [DATA_W-1:0]   evt
);
  logic [NUM_CH-1:0] tx_ev;
  logic [NUM_CH-1:0] rx_ev;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xfer_mode_e m;
    assign m        = xfer_mode_e'(mode[2*c +: 2]);
    assign tx_ev[c] = txs[c] && (m != XFER_RX_ONLY);
    assign rx_ev[c] = rxs[c] && (m != XFER_TX_ONLY) && !turbo[c];
  end

  always_comb begin
    evt = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      evt[4*c]   = tx_ev[c];
      evt[4*c+2] = rx_ev[c];
    end
  end
endmodule

// File: rtl/spi_irq_cfg_regs.sv
module spi_irq_cfg_regs
  import spi_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  wr_sel_t              sel,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    config_q,
  output logic                 wake_q,
  output logic [TEST_W-1:0]    test_q,
  output logic [MODECTL_W-1:0] modectl_q,
  output logic                 soft_rst,
  output logic                 force_all,
  output logic                 clr_lock
);
  assign soft_rst  = wr && sel.config_r && wdata[SOFTRST_BIT];
  assign clr_lock  = modectl_q[TESTMODE_BIT] && test_q[FORCE_BIT];
  assign force_all = wr && ((sel.test_r && wdata[FORCE_BIT] && modectl_q[TESTMODE_BIT]) ||
                            (sel.modectl_r && wdata[TESTMODE_BIT] && test_q[FORCE_BIT]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      config_q  <= '0;
      wake_q    <= 1'b0;
      test_q    <= '0;
      modectl_q <= MODECTL_DEFAULT;
    end else if (soft_rst) begin
      config_q  <= wdata & CONFIG_KEEP;
      wake_q    <= 1'b0;
      test_q    <= '0;
      modectl_q <= MODECTL_DEFAULT;
    end else if (wr) begin
      if (sel.config_r)  config_q  <= wdata & CONFIG_KEEP;
      if (sel.wake_r)    wake_q    <= wdata[0];
      if (sel.test_r)    test_q    <= wdata[TEST_W-1:0];
      if (sel.modectl_r) modectl_q <= wdata[MODECTL_W-1:0];
    end
  end

  // R10
  softrst_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (modectl_q == MODECTL_DEFAULT) && (test_q == '0) && !wake_q);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt,
  input  logic              wr_status,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wdata,
  input  logic              soft_rst,
  input  logic              force_all,
  input  logic              clr_lock,
  output logic [DATA_W-1:0] status_q,
  output logic [DATA_W-1:0] enable_q,
  output logic              irq
);
  localparam logic [DATA_W-1:0] IMPL = impl_mask(NUM_CH);

  logic [DATA_W-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (wr_status && !clr_lock) status_d = status_d & ~wdata;
    if (force_all)              status_d = status_d | IMPL;
    status_d = status_d | (evt & IMPL);
    if (soft_rst)               status_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      if (soft_rst)       enable_q <= '0;
      else if (wr_enable) enable_q <= wdata & IMPL;
    end
  end

  assign irq = |(status_q & enable_q);

  // R2
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && ((evt & IMPL) != '0)) |=>
      ((status_q & $past(evt & IMPL)) == $past(evt & IMPL)));
  // R7
  clear_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && clr_lock && !soft_rst) |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R8
  force_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_all |=> ((status_q & IMPL) == IMPL));
  // R6
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q | enable_q) & ~IMPL) == '0);
  // R10
  softrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (status_q == '0) && (enable_q == '0) && !irq);
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  input  logic [NUM_CH-1:0]   ch_txs,
  input  logic [NUM_CH-1:0]   ch_rxs,
  input  logic [2*NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0]   ch_turbo,
  output logic                irq
);
  wr_sel_t                sel;
  logic [DATA_W-1:0]      evt;
  logic [DATA_W-1:0]      config_q;
  logic                   wake_q;
  logic [TEST_W-1:0]      test_q;
  logic [MODECTL_W-1:0]   modectl_q;
  logic                   soft_rst;
  logic                   force_all;
  logic                   clr_lock;
  logic [DATA_W-1:0]      status_q;
  logic [DATA_W-1:0]      enable_q;
  logic [DATA_W-1:0]      rd_mux;

  always_comb begin
    sel.config_r  = (reg_addr == ADDR_W'(OFF_CONFIG));
    sel.status_r  = (reg_addr == ADDR_W'(OFF_STATUS));
    sel.enable_r  = (reg_addr == ADDR_W'(OFF_ENABLE));
    sel.wake_r    = (reg_addr == ADDR_W'(OFF_WAKE));
    sel.test_r    = (reg_addr == ADDR_W'(OFF_TEST));
    sel.modectl_r = (reg_addr == ADDR_W'(OFF_MODECTL));
  end

  spi_irq_event_gen #(.NUM_CH(NUM_CH)) u_evt (
    .txs(ch_txs), .rxs(ch_rxs), .turbo(ch_turbo), .mode(ch_mode), .evt(evt)
  );

  spi_irq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .config_q(config_q), .wake_q(wake_q), .test_q(test_q), .modectl_q(modectl_q),
    .soft_rst(soft_rst), .force_all(force_all), .clr_lock(clr_lock)
  );

  spi_irq_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .wr_status(reg_wr && sel.status_r), .wr_enable(reg_wr && sel.enable_r),
    .wdata(reg_wdata), .soft_rst(soft_rst), .force_all(force_all), .clr_lock(clr_lock),
    .status_q(status_q), .enable_q(enable_q), .irq(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFF_IDENT))   rd_mux = IDENT_VALUE;
    if (reg_addr == ADDR_W'(OFF_DONE))    rd_mux = 32'd1;
    if (sel.config_r)                     rd_mux = config_q;
    if (sel.status_r)                     rd_mux = status_q;
    if (sel.enable_r)                     rd_mux = enable_q;
    if (sel.wake_r)                       rd_mux = {{(DATA_W-1){1'b0}}, wake_q};
    if (sel.test_r)                       rd_mux = {{(DATA_W-TEST_W){1'b0}}, test_q};
    if (sel.modectl_r)                    rd_mux = {{(DATA_W-MODECTL_W){1'b0}}, modectl_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // R1
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
endmodule

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic [NUM_CH-1:0] ch_txs = '0, ch_rxs = '0, ch_turbo = '0;
  logic [2*NUM_CH-1:0] ch_mode = '0;
  logic irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_irq_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .ch_txs(ch_txs), .ch_rxs(ch_rxs), .ch_mode(ch_mode), .ch_turbo(ch_turbo), .irq(irq)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops one expected item per read result.
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read: got %h expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          fails++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: got irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic pulse(input logic [3:0] tx, input logic [3:0] rx);
    @(negedge clk);
    ch_txs = tx; ch_rxs = rx;
    @(negedge clk);
    ch_txs = '0; ch_rxs = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and fixed values
    rd(8'h00, 32'h91, "R1 ident");
    rd(8'h04, 32'h1, "R1 done");
    rd(8'h1C, 32'h4, "R1 modectl");
    rd(8'h0C, 32'h0, "R1 status");
    rd(8'h10, 32'h0, "R1 enable");
    rd(8'h18, 32'h0, "R1 test");
    rd(8'h40, 32'h0, "R1 unmapped");
    chk_irq(1'b0, "R1 irq");
    // R2: ch1 receive-only suppressed, ch2 duplex and ch3 transmit-only fire
    ch_mode = 8'b10_00_01_00;
    pulse(4'b1110, 4'b0000);
    rd(8'h0C, 32'h1100, "R2 tx events");
    // R4 write-one-to-clear
    wr(8'h0C, 32'h100);
    rd(8'h0C, 32'h1000, "R4 clear one bit");
    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h1000, "R4 zero write");
    wr(8'h0C, 32'h1000);
    rd(8'h0C, 32'h0, "R4 clear rest");
    // R3: ch1 turbo and ch2 transmit-only suppressed
    ch_mode = 8'b01_10_00_00; ch_turbo = 4'b0010;
    pulse(4'b0000, 4'b1111);
    rd(8'h0C, 32'h4004, "R3 rx events");
    ch_turbo = '0; ch_mode = '0;
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R4 clear all");
    // R6 enable mask and irq
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h1777F, "R6 enable mask");
    chk_irq(1'b0, "R6 irq idle");
    pulse(4'b0001, 4'b0000);
    chk_irq(1'b1, "R6 irq set");
    wr(8'h10, 32'h0);
    chk_irq(1'b0, "R6 irq masked");
    wr(8'h10, 32'h1);
    chk_irq(1'b1, "R6 irq unmasked");
    wr(8'h0C, 32'h1);
    chk_irq(1'b0, "R6 irq cleared");
    // R5 event beats clear
    @(negedge clk); ch_txs = 4'b0001;
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h1, "R5 event wins");
    @(negedge clk); ch_txs = '0;
    wr(8'h0C, 32'h1);
    rd(8'h0C, 32'h0, "R5 cleared after");
    // R9 storage widths
    wr(8'h14, 32'hFF);
    rd(8'h14, 32'h1, "R9 wake");
    wr(8'h08, 32'hFFFF_FFFD);
    rd(8'h08, 32'h31D, "R9 config");
    wr(8'h18, 32'hFFFF_F7FF);
    rd(8'h18, 32'h7FF, "R9 test");
    wr(8'h1C, 32'hFFFF_FFF3);
    rd(8'h1C, 32'h3, "R9 modectl");
    // R8 first arm test then mode control
    wr(8'h18, 32'h800);
    rd(8'h0C, 32'h0, "R8 no force yet");
    wr(8'h1C, 32'h8);
    rd(8'h0C, 32'h1777F, "R8 force via modectl");
    // R7 lockout
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h1777F, "R7 clear locked");
    wr(8'h18, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R7 unlocked clear");
    // R8 force via test write while mode bit set
    wr(8'h18, 32'h800);
    rd(8'h0C, 32'h1777F, "R8 force via test");
    // R10 soft reset
    wr(8'h08, 32'h12);
    rd(8'h08, 32'h10, "R10 config kept");
    rd(8'h0C, 32'h0, "R10 status");
    rd(8'h10, 32'h0, "R10 enable");
    rd(8'h14, 32'h0, "R10 wake");
    rd(8'h18, 32'h0, "R10 test");
    rd(8'h1C, 32'h4, "R10 modectl");
    chk_irq(1'b0, "R10 irq");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL pending reads: got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule